// File: doc/BRIEF.md
# Power Management Register Block

This block is a memory-mapped register file that stands in front of a power management controller. Software programs a requested 2-bit power state for each of 64 logical subsystems in four state-control words. It then issues an apply-configuration command through the command word. The block holds a busy flag for a programmable number of clocks. When the busy period ends, it copies every requested state into four read-only state-status words and pulses a completion strobe.

An interrupt control/status word records the cause of the latest event. It also holds an enable bit, a sticky pending flag and a software interrupt bit. Events that can raise an interrupt are: command completion (when requested), a command error, a command that cannot be accepted in trigger mode, and a newly latched wake source. Two wake-enable words select which of 64 wake inputs are latched into two sticky wake-status words.

The bus is a simple single-cycle 32-bit interface. Writes take effect at the clock edge. Read data is a combinational function of the address.

Top module: `pmu_regfile`

## Requirements
- R1: After a synchronous active-low reset, the following hold. The status word (0x00) reads 0, the command word (0x04) reads 0 and the interrupt word (0x08) reads 0. Wake-enable (0x10, 0x14) and wake-status (0x18, 0x1C) read 0. All state-control (0x20..0x2C) and state-status (0x30..0x3C) words read 0xFFFFFFFF. `irq` and `cmd_done` are low.
- R2: The command word has the opcode in bits 7:0, completion-interrupt request in bit 8 and mode in bits 10:9 (0 none, 1 immediate, 2 delayed, 3 trigger). A write of opcode 0x01 in immediate mode while idle is accepted. Status bit 8 (busy) then reads 1 for exactly BUSY_CYCLES cycles after the accepting edge, and the accepted value reads back from 0x04.
- R3: State-status words change only at the edge that ends a busy period. At that edge they take the values the state-control words held before that edge. Subsystem n occupies bits (2n)%32+1:(2n)%32 of state word (2n)/32.
- R4: `cmd_done` is high for exactly one cycle, the first cycle in which busy reads 0 after a busy period.
- R5: If bit 8 of the accepted command was set and the interrupt enable was set, the ending edge records cause 1 and sets pending.
- R6: A command write with nonzero mode while busy is rejected. The busy period length and the 0x04 readback are unchanged, and cause 2 with pending is recorded if interrupts are enabled.
- R7: A command with nonzero mode and an opcode other than 0x01, written while idle, starts no busy period and leaves the state-status words unchanged. It records cause 2 with pending if interrupts are enabled.
- R8: A command write with mode 0 has no effect on busy, on the 0x04 readback or on the interrupt word.
- R9: An opcode 0x01 command in delayed mode holds busy for BUSY_CYCLES + DELAY_CYCLES cycles.
- R10: An opcode 0x01 command in trigger mode starts no busy period and records cause 7 with pending if interrupts are enabled.
- R11: The interrupt word has cause in bits 7:0, enable in bit 8, pending in bit 9 and software interrupt in bit 10. Bits 8 and 10 are read/write. Writing 1 to bit 9 clears pending. `irq` is enable AND (pending OR software bit). With enable 0, no event sets pending.
- R12: A wake-status bit is set when its wake input and its enable bit are both high. It stays set until a 1 is written to it. A bit that newly becomes set records cause 3 with pending if interrupts are enabled. Inputs whose enable bit is 0 are ignored.
- R13: When several causes arise at one edge, the largest code is recorded. An event that sets pending wins over a pending-clear write in the same edge. Interrupt enable is sampled as it stood before the edge.
- R14: Writes to state-status words and to unmapped or non-word-aligned addresses are ignored. Reads of unmapped or non-word-aligned addresses return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe for the addressed word |
| bus_addr | input | ADDR_W (8) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed word |
| wake_src | input | WAKE_REGS*32 (64) | Level wake inputs, bit i maps to wake word i/32 bit i%32 |
| irq | output | 1 | Interrupt request |
| cmd_done | output | 1 | One-cycle pulse after a busy period ends |

## Verification
Two pairs of functions can land on the same edge and are deliberately made to collide. In the first, a busy period ends while a new command is written. The bench places the second write exactly on the cycle whose edge ends the busy period and expects the state copy, the done pulse and cause 2 (the error) over cause 1. In the second, a new wake bit latches in the very edge where software writes the pending-clear bit, and the bench expects pending to stay set with cause 3. A behavioural model in the bench, built from integers and per-word arrays, steps on every edge. It is compared against `irq`, `cmd_done` and the read data of the currently addressed word.

// File: rtl/pmu_pkg.sv
// Package: shared encodings of the power management register block.
// Assumes 32-bit registers and the fixed word map used by pmu_regfile.
package pmu_pkg;

    localparam int REG_W = 32;

    // Opcode of the apply-configuration command
    localparam logic [7:0] OP_APPLY_CFG = 8'h01;

    typedef enum logic [1:0] {
        MODE_NONE    = 2'd0,
        MODE_IMMED   = 2'd1,
        MODE_DELAYED = 2'd2,
        MODE_TRIGGER = 2'd3
    } cmd_mode_e;

    typedef enum logic [7:0] {
        CAUSE_NONE      = 8'd0,
        CAUSE_DONE      = 8'd1,
        CAUSE_CMD_ERR   = 8'd2,
        CAUSE_WAKE      = 8'd3,
        CAUSE_PWR_ERR   = 8'd4,
        CAUSE_IDLE_ERR  = 8'd5,
        CAUSE_NO_DEEP   = 8'd6,
        CAUSE_TRIG_ERR  = 8'd7,
        CAUSE_INACTIVE  = 8'd8
    } irq_cause_e;

    // Command word layout: mode[10:9], completion request[8], opcode[7:0]
    typedef struct packed {
        cmd_mode_e   mode;
        logic        ioc;
        logic [7:0]  op;
    } cmd_word_t;

    // Word indices (byte address / 4) of the fixed registers
    localparam int IDX_STS  = 0;
    localparam int IDX_CMD  = 1;
    localparam int IDX_ICS  = 2;
    localparam int IDX_WAKE = 4;

endpackage

// File: rtl/pmu_cmd_engine.sv
// Module: command engine. Decodes writes to the command word, runs the
// busy period and flags the edge where the state copy happens.
// Assumes BUSY_CYCLES >= 1; commands written while busy are rejected.
module pmu_cmd_engine
    import pmu_pkg::*;
#(
    parameter int BUSY_CYCLES  = 8,
    parameter int DELAY_CYCLES = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cmd_we,
    input  cmd_word_t cmd_in,
    output logic      busy_o,
    output logic      done_o,
    output logic      complete_o,
    output logic      ev_done_o,
    output logic      ev_err_o,
    output logic      ev_trig_o,
    output cmd_word_t cmd_q_o
);

    localparam int LONGEST = BUSY_CYCLES + DELAY_CYCLES;
    localparam int CNT_W   = (LONGEST > 1) ? $clog2(LONGEST) : 1;

    logic             busy_q;
    logic             done_q;
    logic             ioc_q;
    logic [CNT_W-1:0] cnt_q;
    cmd_word_t        cmd_q;

    logic active, accept, reject_busy, bad_op, trig_mode, complete;

    // Classify the incoming command write
    always_comb begin
        active      = cmd_we && (cmd_in.mode != MODE_NONE);
        reject_busy = active && busy_q;
        bad_op      = active && !busy_q && (cmd_in.op != OP_APPLY_CFG);
        trig_mode   = active && !busy_q && (cmd_in.op == OP_APPLY_CFG)
                      && (cmd_in.mode == MODE_TRIGGER);
        accept      = active && !busy_q && (cmd_in.op == OP_APPLY_CFG)
                      && (cmd_in.mode != MODE_TRIGGER);
        complete    = busy_q && (cnt_q == '0);
    end

    // Busy period counter and accepted-command latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            ioc_q  <= 1'b0;
            cmd_q  <= '0;
        end else if (accept) begin
            busy_q <= 1'b1;
            ioc_q  <= cmd_in.ioc;
            cmd_q  <= cmd_in;
            cnt_q  <= (cmd_in.mode == MODE_DELAYED) ? CNT_W'(LONGEST - 1)
                                                    : CNT_W'(BUSY_CYCLES - 1);
        end else if (complete) begin
            busy_q <= 1'b0;
        end else if (busy_q) begin
            cnt_q  <= cnt_q - 1'b1;
        end
    end

    // One-cycle completion strobe
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= complete;
    end

    assign busy_o     = busy_q;
    assign done_o     = done_q;
    assign complete_o = complete;
    assign ev_done_o  = complete && ioc_q;
    assign ev_err_o   = reject_busy || bad_op;
    assign ev_trig_o  = trig_mode;
    assign cmd_q_o    = cmd_q;

    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && cnt_q != '0) |=> busy_q); // R2
    AST_DONE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> done_q); // R4
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q); // R4
    AST_REJECT_KEEPS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && busy_q) |=> $stable(cmd_q)); // R6
    AST_IDLE_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_q && (!cmd_we || cmd_in.mode == MODE_NONE)) |=> !busy_q); // R8

endmodule

// File: rtl/pmu_state_bank.sv
// Module: per-subsystem power state words. Control words are written by
// software; status words load all control words at the completion edge.
// Assumes 2 bits per subsystem packed 16 per word.
module pmu_state_bank
    import pmu_pkg::*;
#(
    parameter int NUM_WORDS = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_WORDS-1:0]              ctrl_we,
    input  logic [REG_W-1:0]                  wdata,
    input  logic                              complete_i,
    output logic [NUM_WORDS-1:0][REG_W-1:0]   ctrl_o,
    output logic [NUM_WORDS-1:0][REG_W-1:0]   stat_o
);

    logic [NUM_WORDS-1:0][REG_W-1:0] ctrl_q;
    logic [NUM_WORDS-1:0][REG_W-1:0] stat_q;

    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
        // Requested states, written by software
        always_ff @(posedge clk) begin
            if (!rst_n)          ctrl_q[g] <= '1;
            else if (ctrl_we[g]) ctrl_q[g] <= wdata;
        end

        // Reported states, loaded when a command completes
        always_ff @(posedge clk) begin
            if (!rst_n)          stat_q[g] <= '1;
            else if (complete_i) stat_q[g] <= ctrl_q[g];
        end
    end

    assign ctrl_o = ctrl_q;
    assign stat_o = stat_q;

    AST_STAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !complete_i |=> $stable(stat_q)); // R3
    AST_STAT_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        complete_i |=> (stat_q == $past(ctrl_q))); // R3

endmodule

// File: rtl/pmu_wake_unit.sv
// Module: wake enables and sticky wake status with write-one-to-clear.
// Assumes level wake inputs synchronous to clk; reports newly set bits.
module pmu_wake_unit
    import pmu_pkg::*;
#(
    parameter int NUM_WORDS = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_WORDS-1:0]              en_we,
    input  logic [NUM_WORDS-1:0]              sts_we,
    input  logic [REG_W-1:0]                  wdata,
    input  logic [NUM_WORDS*REG_W-1:0]        src_i,
    output logic [NUM_WORDS-1:0][REG_W-1:0]   en_o,
    output logic [NUM_WORDS-1:0][REG_W-1:0]   sts_o,
    output logic                              ev_wake_o
);

    logic [NUM_WORDS-1:0][REG_W-1:0] en_q;
    logic [NUM_WORDS-1:0][REG_W-1:0] sts_q;
    logic [NUM_WORDS-1:0][REG_W-1:0] hit;
    logic [NUM_WORDS-1:0]            fresh;

    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
        logic [REG_W-1:0] clr_mask;

        // Enabled wake inputs for this word and clear mask of this write
        always_comb begin
            hit[g]   = src_i[g*REG_W +: REG_W] & en_q[g];
            fresh[g] = |(hit[g] & ~sts_q[g]);
            clr_mask = sts_we[g] ? wdata : '0;
        end

        // Wake enable word
        always_ff @(posedge clk) begin
            if (!rst_n)        en_q[g] <= '0;
            else if (en_we[g]) en_q[g] <= wdata;
        end

        // Sticky status: set wins over clear
        always_ff @(posedge clk) begin
            if (!rst_n) sts_q[g] <= '0;
            else        sts_q[g] <= (sts_q[g] & ~clr_mask) | hit[g];
        end

        AST_WAKE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            !sts_we[g] |=> ((sts_q[g] & $past(sts_q[g])) == $past(sts_q[g]))); // R12
    end

    assign en_o      = en_q;
    assign sts_o     = sts_q;
    assign ev_wake_o = |fresh;

endmodule

// File: rtl/pmu_irq_ctrl.sv
// Module: interrupt cause, enable, pending and software bits.
// Assumes events are single-cycle; the largest cause code of an edge wins.
module pmu_irq_ctrl
    import pmu_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ev_done_i,
    input  logic       ev_err_i,
    input  logic       ev_wake_i,
    input  logic       ev_trig_i,
    input  logic       ics_we,
    input  logic [2:0] ics_wdata,
    output logic       ie_o,
    output logic       pend_o,
    output logic       sw_o,
    output logic [7:0] cause_o,
    output logic       irq_o
);

    logic       ie_q, pend_q, sw_q;
    irq_cause_e cause_q;
    irq_cause_e new_cause;
    logic       any_ev;
    logic       clr_req;

    // Pick the largest cause code among this edge's events
    always_comb begin
        any_ev  = ev_done_i || ev_err_i || ev_wake_i || ev_trig_i;
        clr_req = ics_we && ics_wdata[1];
        if (ev_trig_i)      new_cause = CAUSE_TRIG_ERR;
        else if (ev_wake_i) new_cause = CAUSE_WAKE;
        else if (ev_err_i)  new_cause = CAUSE_CMD_ERR;
        else if (ev_done_i) new_cause = CAUSE_DONE;
        else                new_cause = CAUSE_NONE;
    end

    // Cause and pending: a recorded event beats a clear request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_q <= CAUSE_NONE;
            pend_q  <= 1'b0;
        end else if (ie_q && any_ev) begin
            cause_q <= new_cause;
            pend_q  <= 1'b1;
        end else if (clr_req) begin
            pend_q  <= 1'b0;
        end
    end

    // Enable and software bits are plain read/write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_q <= 1'b0;
            sw_q <= 1'b0;
        end else if (ics_we) begin
            ie_q <= ics_wdata[0];
            sw_q <= ics_wdata[2];
        end
    end

    assign ie_o    = ie_q;
    assign pend_o  = pend_q;
    assign sw_o    = sw_q;
    assign cause_o = cause_q;
    assign irq_o   = ie_q && (pend_q || sw_q);

    AST_PEND_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |-> (cause_q != CAUSE_NONE)); // R5
    AST_EVENT_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (ie_q && any_ev) |=> pend_q); // R13
    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !(ie_q && any_ev)) |=> !pend_q); // R11
    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!ie_q && !pend_q) |=> !pend_q); // R11

endmodule

// File: rtl/pmu_regfile.sv
// Module: top of the power management register block. Decodes the word
// address, routes writes to the sub-units and multiplexes read data.
// Assumes word-aligned accesses; others are ignored and read as zero.
module pmu_regfile
    import pmu_pkg::*;
#(
    parameter int NUM_SUBSYS   = 64,
    parameter int WAKE_REGS    = 2,
    parameter int BUSY_CYCLES  = 8,
    parameter int DELAY_CYCLES = 4,
    parameter int ADDR_W       = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_we,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [REG_W-1:0]            bus_wdata,
    output logic [REG_W-1:0]            bus_rdata,
    input  logic [WAKE_REGS*REG_W-1:0]  wake_src,
    output logic                        irq,
    output logic                        cmd_done
);

    localparam int STATE_REGS = (NUM_SUBSYS * 2) / REG_W;
    localparam int IDX_W      = ADDR_W - 2;
    localparam int IDX_WSTS   = IDX_WAKE + WAKE_REGS;
    localparam int IDX_CTRL   = 8;
    localparam int IDX_STAT   = IDX_CTRL + STATE_REGS;

    logic             aligned;
    logic [IDX_W-1:0] widx;
    logic             cmd_we, ics_we;
    logic [WAKE_REGS-1:0]  wen_we, wsts_we;
    logic [STATE_REGS-1:0] ctrl_we;

    logic      busy, complete, ev_done, ev_err, ev_trig, ev_wake;
    cmd_word_t cmd_q;
    logic      ie, pend, sw;
    logic [7:0] cause;
    logic [WAKE_REGS-1:0][REG_W-1:0]  wen, wsts;
    logic [STATE_REGS-1:0][REG_W-1:0] ctrl, stat;

    // Address split and fixed-word write strobes
    always_comb begin
        aligned = (bus_addr[1:0] == 2'b00);
        widx    = bus_addr[ADDR_W-1:2];
        cmd_we  = bus_we && aligned && (widx == IDX_W'(IDX_CMD));
        ics_we  = bus_we && aligned && (widx == IDX_W'(IDX_ICS));
    end

    for (genvar g = 0; g < WAKE_REGS; g++) begin : g_wake_dec
        assign wen_we[g]  = bus_we && aligned && (widx == IDX_W'(IDX_WAKE + g));
        assign wsts_we[g] = bus_we && aligned && (widx == IDX_W'(IDX_WSTS + g));
    end

    for (genvar g = 0; g < STATE_REGS; g++) begin : g_state_dec
        assign ctrl_we[g] = bus_we && aligned && (widx == IDX_W'(IDX_CTRL + g));
    end

    pmu_cmd_engine #(
        .BUSY_CYCLES (BUSY_CYCLES),
        .DELAY_CYCLES(DELAY_CYCLES)
    ) u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_we    (cmd_we),
        .cmd_in    (cmd_word_t'(bus_wdata[10:0])),
        .busy_o    (busy),
        .done_o    (cmd_done),
        .complete_o(complete),
        .ev_done_o (ev_done),
        .ev_err_o  (ev_err),
        .ev_trig_o (ev_trig),
        .cmd_q_o   (cmd_q)
    );

    pmu_state_bank #(
        .NUM_WORDS(STATE_REGS)
    ) u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_we   (ctrl_we),
        .wdata     (bus_wdata),
        .complete_i(complete),
        .ctrl_o    (ctrl),
        .stat_o    (stat)
    );

    pmu_wake_unit #(
        .NUM_WORDS(WAKE_REGS)
    ) u_wake (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_we    (wen_we),
        .sts_we   (wsts_we),
        .wdata    (bus_wdata),
        .src_i    (wake_src),
        .en_o     (wen),
        .sts_o    (wsts),
        .ev_wake_o(ev_wake)
    );

    pmu_irq_ctrl u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_done_i(ev_done),
        .ev_err_i (ev_err),
        .ev_wake_i(ev_wake),
        .ev_trig_i(ev_trig),
        .ics_we   (ics_we),
        .ics_wdata(bus_wdata[10:8]),
        .ie_o     (ie),
        .pend_o   (pend),
        .sw_o     (sw),
        .cause_o  (cause),
        .irq_o    (irq)
    );

    // Read multiplexer over all mapped words
    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            if (widx == IDX_W'(IDX_STS)) bus_rdata = {23'd0, busy, 8'd0};
            if (widx == IDX_W'(IDX_CMD)) bus_rdata = {21'd0, cmd_q};
            if (widx == IDX_W'(IDX_ICS)) bus_rdata = {21'd0, sw, pend, ie, cause};
            for (int r = 0; r < WAKE_REGS; r++) begin
                if (widx == IDX_W'(IDX_WAKE + r)) bus_rdata = wen[r];
                if (widx == IDX_W'(IDX_WSTS + r)) bus_rdata = wsts[r];
            end
            for (int r = 0; r < STATE_REGS; r++) begin
                if (widx == IDX_W'(IDX_CTRL + r)) bus_rdata = ctrl[r];
                if (widx == IDX_W'(IDX_STAT + r)) bus_rdata = stat[r];
            end
        end
    end

    AST_UNALIGNED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !aligned |-> (bus_rdata == '0)); // R14
    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ie); // R11

endmodule

// File: tb/pmu_regfile_tb.sv
module pmu_regfile_tb;

    localparam int CLK_PERIOD = 20;
    localparam int BUSY  = 8;
    localparam int DLY   = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic [63:0] wake_src = 64'h0;
    logic        irq;
    logic        cmd_done;

    int chk_cnt = 0;
    int fail_cnt = 0;

    pmu_regfile #(
        .NUM_SUBSYS(64), .WAKE_REGS(2), .BUSY_CYCLES(BUSY),
        .DELAY_CYCLES(DLY), .ADDR_W(8)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wake_src(wake_src),
        .irq(irq), .cmd_done(cmd_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // ---------------- behavioural reference model ----------------
    int          m_left;
    logic [31:0] m_ctrl [4];
    logic [31:0] m_stat [4];
    logic [31:0] m_wken [2];
    logic [31:0] m_wks  [2];
    logic [10:0] m_cmd;
    logic        m_ioc, m_ie, m_pend, m_sw, m_done;
    logic [7:0]  m_cause;

    function automatic logic [31:0] mread(input logic [7:0] a);
        int w;
        if (a[1:0] != 2'b00) return 32'h0;
        w = int'(a[7:2]);
        if (w == 0) return (m_left > 0) ? 32'h100 : 32'h0;
        if (w == 1) return {21'd0, m_cmd};
        if (w == 2) return {21'd0, m_sw, m_pend, m_ie, m_cause};
        if (w >= 4 && w <= 5)  return m_wken[w-4];
        if (w >= 6 && w <= 7)  return m_wks[w-6];
        if (w >= 8 && w <= 11) return m_ctrl[w-8];
        if (w >= 12 && w <= 15) return m_stat[w-12];
        return 32'h0;
    endfunction

    task automatic model_step();
        logic [31:0] ctrl_pre [4];
        logic [31:0] wken_pre [2];
        logic [31:0] clr [2];
        logic        busy_pre, ie_new, clr_pend, sw_new;
        int          ev, w;
        if (!rst_n) begin
            m_left = 0; m_cmd = '0; m_ioc = 0; m_ie = 0; m_pend = 0;
            m_sw = 0; m_done = 0; m_cause = 0;
            for (int i = 0; i < 4; i++) begin m_ctrl[i] = '1; m_stat[i] = '1; end
            for (int i = 0; i < 2; i++) begin m_wken[i] = '0; m_wks[i] = '0; end
            return;
        end
        for (int i = 0; i < 4; i++) ctrl_pre[i] = m_ctrl[i];
        for (int i = 0; i < 2; i++) begin wken_pre[i] = m_wken[i]; clr[i] = '0; end
        busy_pre = (m_left > 0);
        ev = 0; ie_new = m_ie; clr_pend = 0; sw_new = m_sw;
        m_done = (m_left == 1);
        if (m_left == 1) begin
            for (int i = 0; i < 4; i++) m_stat[i] = ctrl_pre[i];
            if (m_ioc) ev = 1;
        end
        if (m_left > 0) m_left--;
        if (bus_we && bus_addr[1:0] == 2'b00) begin
            w = int'(bus_addr[7:2]);
            if (w == 1 && bus_wdata[10:9] != 2'd0) begin
                if (busy_pre || bus_wdata[7:0] != 8'h01) ev = (ev > 2) ? ev : 2;
                else if (bus_wdata[10:9] == 2'd3) ev = 7;
                else begin
                    m_left = (bus_wdata[10:9] == 2'd1) ? BUSY : BUSY + DLY;
                    m_ioc  = bus_wdata[8];
                    m_cmd  = bus_wdata[10:0];
                end
            end
            if (w == 2) begin
                ie_new = bus_wdata[8]; clr_pend = bus_wdata[9]; sw_new = bus_wdata[10];
            end
            if (w >= 4 && w <= 5) m_wken[w-4] = bus_wdata;
            if (w >= 6 && w <= 7) clr[w-6] = bus_wdata;
            if (w >= 8 && w <= 11) m_ctrl[w-8] = bus_wdata;
        end
        for (int i = 0; i < 2; i++) begin
            logic [31:0] h;
            h = wake_src[i*32 +: 32] & wken_pre[i];
            if ((h & ~m_wks[i]) != 0) ev = (ev > 3) ? ev : 3;
            m_wks[i] = (m_wks[i] & ~clr[i]) | h;
        end
        if (m_ie && ev != 0) begin m_cause = 8'(ev); m_pend = 1; end
        else if (clr_pend) m_pend = 0;
        m_ie = ie_new; m_sw = sw_new;
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        chk_cnt++;
        if (act !== exp) begin
            fail_cnt++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
        end
    endtask

    // Model steps on each edge and is compared just after it
    always @(posedge clk) begin
        model_step();
        #1;
        check("R4 cycle model cmd_done", {31'd0, cmd_done}, {31'd0, m_done});
        check("R11 cycle model irq", {31'd0, irq}, {31'd0, m_ie && (m_pend || m_sw)});
        check("R3 cycle model read data", bus_rdata, mread(bus_addr));
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rdc(input logic [7:0] a, input logic [31:0] exp, input string tag);
        bus_addr = a;
        #1;
        check(tag, bus_rdata, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", chk_cnt, fail_cnt);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        chk_cnt++; fail_cnt++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        rdc(8'h00, 32'h0, "R1 status");
        rdc(8'h08, 32'h0, "R1 irq word");
        rdc(8'h20, 32'hFFFF_FFFF, "R1 ctrl0");
        rdc(8'h3C, 32'hFFFF_FFFF, "R1 stat3");
        rdc(8'h14, 32'h0, "R1 wake enable1");
        check("R1 irq low", {31'd0, irq}, 32'h0);
        idle(1);
        // R11 enable
        wr(8'h08, 32'h100);
        rdc(8'h08, 32'h100, "R11 enable readback");
        // R3 program: subsystem 1 -> state 1, subsystem 63 -> state 1
        wr(8'h20, 32'h0000_0004);
        wr(8'h2C, 32'h4000_0000);
        rdc(8'h30, 32'hFFFF_FFFF, "R3 status before command");
        // R2 immediate command with completion interrupt
        wr(8'h04, 32'h301);
        for (int i = 0; i < BUSY; i++) begin
            rdc(8'h00, 32'h100, "R2 busy during period");
            @(negedge clk);
        end
        rdc(8'h00, 32'h0, "R2 busy ends");
        check("R4 done pulse", {31'd0, cmd_done}, 32'h1);
        rdc(8'h30, 32'h0000_0004, "R3 stat0 copied");
        rdc(8'h3C, 32'h4000_0000, "R3 stat3 copied");
        rdc(8'h04, 32'h301, "R2 command readback");
        rdc(8'h08, 32'h301, "R5 completion cause");
        @(negedge clk);
        check("R4 done single cycle", {31'd0, cmd_done}, 32'h0);
        rdc(8'h34, 32'hFFFF_FFFF, "R3 stat1 unchanged");
        // R11 pending clear and software bit
        wr(8'h08, 32'h300);
        rdc(8'h08, 32'h101, "R11 pending cleared");
        check("R11 irq after clear", {31'd0, irq}, 32'h0);
        wr(8'h08, 32'h500);
        check("R11 software irq", {31'd0, irq}, 32'h1);
        wr(8'h08, 32'h100);
        // R8 mode none
        wr(8'h04, 32'h001);
        rdc(8'h00, 32'h0, "R8 no busy");
        rdc(8'h04, 32'h301, "R8 readback kept");
        rdc(8'h08, 32'h101, "R8 irq word kept");
        // R7 unknown opcode
        wr(8'h04, 32'h205);
        rdc(8'h00, 32'h0, "R7 no busy");
        rdc(8'h08, 32'h302, "R7 error cause");
        rdc(8'h30, 32'h0000_0004, "R7 state unchanged");
        wr(8'h08, 32'h300);
        // R10 trigger mode
        wr(8'h04, 32'h601);
        rdc(8'h00, 32'h0, "R10 no busy");
        rdc(8'h08, 32'h307, "R10 trigger cause");
        wr(8'h08, 32'h300);
        // R9 delayed mode, no completion interrupt
        wr(8'h20, 32'h0000_0010);
        wr(8'h04, 32'h401);
        for (int i = 0; i < BUSY + DLY; i++) begin
            rdc(8'h00, 32'h100, "R9 busy during delayed period");
            @(negedge clk);
        end
        rdc(8'h00, 32'h0, "R9 busy ends");
        rdc(8'h30, 32'h0000_0010, "R9 stat0 copied");
        rdc(8'h08, 32'h107, "R5 no pending without request");
        @(negedge clk);
        // R6 rejection while busy, then R13 collision at the ending edge
        wr(8'h04, 32'h301);
        wr(8'h04, 32'h201);
        rdc(8'h08, 32'h302, "R6 reject cause");
        rdc(8'h04, 32'h301, "R6 readback kept");
        rdc(8'h00, 32'h100, "R6 still busy");
        wr(8'h08, 32'h300);
        idle(BUSY - 3);
        wr(8'h04, 32'h201);
        rdc(8'h00, 32'h0, "R6 period length unchanged");
        check("R4 done at collision", {31'd0, cmd_done}, 32'h1);
        rdc(8'h08, 32'h302, "R13 error beats completion");
        // R12 wake
        wr(8'h08, 32'h300);
        wr(8'h10, 32'h0000_00F0);
        wake_src = 64'h10;
        @(negedge clk);
        wake_src = 64'h0;
        rdc(8'h18, 32'h10, "R12 wake latched");
        rdc(8'h08, 32'h303, "R12 wake cause");
        wr(8'h08, 32'h300);
        wake_src = 64'h1;
        @(negedge clk);
        wake_src = 64'h0;
        rdc(8'h18, 32'h10, "R12 disabled input ignored");
        rdc(8'h08, 32'h103, "R12 no pending from disabled input");
        wr(8'h18, 32'h10);
        rdc(8'h18, 32'h0, "R12 write one clears");
        // R13 clear and new wake in the same edge
        bus_we = 1'b1; bus_addr = 8'h08; bus_wdata = 32'h300; wake_src = 64'h20;
        @(negedge clk);
        bus_we = 1'b0; wake_src = 64'h0;
        rdc(8'h08, 32'h303, "R13 set beats clear");
        rdc(8'h18, 32'h20, "R13 wake latched");
        wr(8'h08, 32'h300);
        // R14 read-only and unmapped
        wr(8'h30, 32'h0);
        rdc(8'h30, 32'h10, "R14 status read-only");
        rdc(8'h0C, 32'h0, "R14 unmapped reads zero");
        rdc(8'h40, 32'h0, "R14 beyond map reads zero");
        wr(8'h25, 32'h0);
        rdc(8'h24, 32'hFFFF_FFFF, "R14 misaligned write ignored");
        // R11 masked: events leave pending clear
        wr(8'h08, 32'h200);
        wr(8'h04, 32'h205);
        rdc(8'h08, 32'h003, "R11 masked error not pending");
        check("R11 masked irq low", {31'd0, irq}, 32'h0);
        idle(2);
        summary();
        $finish;
    end

endmodule